// File: doc/BRIEF.md
# Loadable Right-Shifting Register with Serial Output

This block is a parameterised register of WIDTH bits that converts a parallel word into a serial bit stream. On each rising clock edge it does one of three things: it moves every bit one place toward the least significant end and takes a new bit from the serial input at the top, it captures a full parallel word, or it keeps its contents. The serial output is always the bit held in the least significant position, so a word that has been captured leaves the register lowest bit first.

When both the shift and the load controls are high, shifting takes priority. A synchronous active-high reset clears every bit. The register can also be used as a serial delay line: a bit applied at the serial input appears at the serial output WIDTH-1 clock periods after the edge that captures it.

Top module: `shreg_pload`

## Requirements
- R1: A synchronous active-high reset clears all bits, so after a reset edge par_q is zero and ser_out is 0.
- R2: With shift_en high on a rising edge, bit i takes bit i+1 and the top bit (index WIDTH-1) takes ser_in.
- R3: With shift_en low and load_en high on a rising edge, par_q takes par_d.
- R4: With both shift_en and load_en low, par_q keeps its value across the edge.
- R5: When shift_en and load_en are both high, the register shifts and par_d is ignored.
- R6: ser_out always equals bit 0 of par_q.
- R7: After loading 4'b1011 and then shifting with ser_in held at 0, ser_out shows 1, 1, 0, 1 on successive cycles.
- R8: With shift_en held high, a bit captured from ser_in reaches ser_out WIDTH-1 clock periods after the edge that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| shift_en | input | 1 | Shift toward LSB (priority) |
| load_en | input | 1 | Capture parallel word |
| ser_in | input | 1 | Bit entering at MSB |
| par_d | input | WIDTH | Parallel input word |
| par_q | output | WIDTH | Register contents |
| ser_out | output | 1 | Current LSB |

## Verification
Every register bit is visible on par_q, so a wrong next-state choice shows at the ports on the very next cycle. The cases that need care are the edges where both controls are high, because a wrong priority still gives a plausible word. A corrupted upper bit reaches ser_out only after it has moved down to the bottom, so serial-only checks are paired with full parallel compares.

// File: rtl/shreg_pload.sv
module shreg_pload #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             load_en,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_d,
  output logic [WIDTH-1:0] par_q,
  output logic             ser_out
);
  logic [WIDTH-1:0] nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_left;
    if (i == WIDTH-1) begin : g_top
      assign from_left = ser_in;
    end else begin : g_mid
      assign from_left = par_q[i+1];
    end
    assign nxt[i] = shift_en ? from_left : (load_en ? par_d[i] : par_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) par_q <= '0;
    else     par_q <= nxt;
  end

  assign ser_out = par_q[0];
endmodule

module shreg_pload_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_en,
  input logic             load_en,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_d,
  input logic [WIDTH-1:0] par_q,
  input logic             ser_out
);
  p_clear_r1: assert property (@(posedge clk) rst |=> par_q == '0);
  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> par_q == {$past(ser_in), $past(par_q[WIDTH-1:1])});
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && load_en) |=> par_q == $past(par_d));
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !load_en) |=> $stable(par_q));
  p_prio_r5: assert property (@(posedge clk) disable iff (rst)
    (shift_en && load_en) |=> par_q[WIDTH-2:0] == $past(par_q[WIDTH-1:1]));
  always_comb p_lsb_r6: assert (ser_out === par_q[0]);
endmodule

bind shreg_pload shreg_pload_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/shreg_pload_test.sv
module shreg_pload_test;
  localparam int W = 4;
  logic clk = 0, rst = 1, shift_en = 0, load_en = 0, ser_in = 0;
  logic [W-1:0] par_d = '0;
  logic [W-1:0] par_q;
  logic ser_out;
  int checks = 0, errors = 0;
  logic [W-1:0] exp_q[$];
  string exp_tag[$];
  logic [W-1:0] model = '0;
  bit done = 0;

  shreg_pload #(.WIDTH(W)) uut (.*);

  always #2.5 clk = ~clk;

  task automatic step(input logic sh, input logic ld, input logic si,
                      input logic [W-1:0] d, input string tag);
    shift_en = sh; load_en = ld; ser_in = si; par_d = d;
    if (rst) model = '0;
    else if (sh) model = {si, model[W-1:1]};
    else if (ld) model = d;
    exp_q.push_back(model);
    exp_tag.push_back(tag);
    @(posedge clk);
    #1;
  endtask

  // monitor: compare after each edge, away from it
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = exp_tag.pop_front();
      checks++;
      if (par_q !== e || ser_out !== e[0]) begin
        errors++;
        $display("FAIL %s: par_q=%b ser_out=%b expected %b/%b", t, par_q, ser_out, e, e[0]);
      end
    end
  end

  task automatic chk_bit(input logic exp, input string tag);
    checks++;
    if (ser_out !== exp) begin
      errors++;
      $display("FAIL %s: ser_out=%b expected %b", tag, ser_out, exp);
    end
  endtask

  initial begin
    #2000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    rst = 1;
    step(0, 1, 1, 4'hF, "R1 reset clears");
    rst = 0;
    step(0, 1, 0, 4'b1011, "R3 load");
    step(0, 0, 1, 4'h0, "R4 hold");
    step(0, 0, 0, 4'hF, "R4 hold");
    // R7: LSB-first stream 1,1,0,1
    chk_bit(1, "R7 bit0");
    step(1, 0, 0, 4'h0, "R7 shift");
    chk_bit(1, "R7 bit1");
    step(1, 0, 0, 4'h0, "R7 shift");
    chk_bit(0, "R7 bit2");
    step(1, 0, 0, 4'h0, "R7 shift");
    chk_bit(1, "R7 bit3");
    step(0, 1, 0, 4'b0110, "R3 load");
    step(1, 1, 1, 4'b0000, "R5 shift beats load");
    step(1, 1, 0, 4'b1111, "R5 shift beats load");
    step(1, 0, 1, 4'h0, "R2 shift in 1");
    step(0, 1, 0, 4'h0, "R3 load zero");
    // R8: single 1 at ser_in reaches ser_out after W-1 periods
    step(1, 0, 1, 4'h0, "R8 capture");
    for (int k = 0; k < W-1; k++) begin
      chk_bit(0, "R8 in flight");
      step(1, 0, 0, 4'h0, "R8 shift");
    end
    chk_bit(1, "R8 arrival");
    step(0, 1, 0, 4'b1001, "R6 load");
    chk_bit(1, "R6 lsb");
    rst = 1;
    step(0, 0, 0, 4'h0, "R1 reset again");
    rst = 0;
    step(0, 0, 0, 4'h0, "R1 held clear");
    repeat (2) @(posedge clk);
    #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule